// File: doc/BRIEF.md
# UART Host Register Block

This block is the register front end that a host bus sees in front of a pair of serial engines. The serial engines themselves sit outside it. A single data address serves both directions: a bus write fills a one-byte transmit buffer, and a bus read returns the most recently received byte. A status register gathers five flags: receive-complete, transmit-complete, transmit-buffer-empty, framing-error and overrun. An enable register gates three of these flags onto level interrupt lines.

On the transmit side, the block holds a written byte until the shifter is idle. It then hands the byte over with a one-cycle start pulse. The `tx_busy` input is the only back-pressure: no byte moves while it is high, and a byte written meanwhile simply waits in the buffer. On the receive side, the engine presents each character as a one-cycle `rx_valid` pulse, together with the byte and its sampled stop bit. There is no back-pressure toward the receiver. A character that arrives before the previous one was read replaces it and raises overrun.

Register map (2-bit `bus_addr`): 0 = data, 1 = status, 2 = interrupt enable. Reads are combinational, and the `bus_rd` strobe marks the cycle in which a read takes effect.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the status register reads 0x20 (only the empty flag set), the enable register reads 0, all three interrupt outputs are low and `tx_start` is low.
- R2: Status bit positions are: receive-complete bit 7, transmit-complete bit 6, empty bit 5, framing-error bit 4, overrun bit 3. Bits 2..0 read 0, and writing 1s to status bits 5..0 changes nothing.
- R3: A write to address 0 loads the transmit buffer and clears the empty flag at that clock edge.
- R4: When the buffer holds a byte and `tx_busy` is low, `tx_start` goes high for one cycle on the next edge, with the byte on `tx_data`. The empty flag sets at that same edge.
- R5: A byte written while `tx_busy` is high stays in the buffer with no `tx_start`. It is handed over at the first edge after `tx_busy` is seen low.
- R6: Transmit-complete sets at the edge after `tx_busy` falls. Writing 1 to status bit 6 clears it, and writing 0 there leaves it set.
- R7: Receive-complete sets on each `rx_valid` pulse. Writing 1 to status bit 7 clears it.
- R8: Framing-error is loaded with the inverse of `rx_stop` together with each received byte, so it always describes the byte currently held.
- R9: Overrun sets when `rx_valid` arrives while the previous byte is still unread. A read of address 0 (with `bus_rd`) clears it.
- R10: Reading the status register (with `bus_rd`) changes no flag.
- R11: Enable bit 0 gates receive-complete onto `irq_rx`, bit 1 gates transmit-complete onto `irq_tx`, and bit 2 gates the empty flag onto `irq_empty`. `irq_empty` stays high until the buffer is refilled or bit 2 is cleared.
- R12: A read of address 0 returns the last byte delivered with `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| tx_start | output | 1 | One-cycle handover pulse to the transmit shifter |
| tx_data | output | 8 | Byte handed over with `tx_start` |
| tx_busy | input | 1 | Transmit shifter is sending; high from the cycle after `tx_start` |
| rx_valid | input | 1 | One-cycle pulse: a received character is ready |
| rx_data | input | 8 | Received byte |
| rx_stop | input | 1 | Sampled stop bit of that character |
| irq_rx | output | 1 | Receive-complete interrupt (level) |
| irq_tx | output | 1 | Transmit-complete interrupt (level) |
| irq_empty | output | 1 | Transmit-buffer-empty interrupt (level) |

## Verification
Transmit is driven in two ways. First, a byte is written into an idle shifter to time the one-cycle handover exactly. Second, a byte is written while the shifter is busy, which separates a buffer that waits from one that hands over early. Receive is driven with three characters: a clean one, one with a low stop bit, then a clean one that lands before the previous character is read. This sequence shows that framing-error follows the held byte and that overrun is raised and then cleared by a data read. Status writes with 0, with 1 in the write-one-clear positions and with 1 elsewhere separate correct clearing from clearing on any write.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned IRQ_N  = 3;

  // register selector values
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_IEN  = 2'd2;

  // status bit positions
  localparam int unsigned ST_RXC   = 7;
  localparam int unsigned ST_TXC   = 6;
  localparam int unsigned ST_EMPTY = 5;
  localparam int unsigned ST_FE    = 4;
  localparam int unsigned ST_OVR   = 3;

  // enable / interrupt bit positions
  localparam int unsigned IE_RX    = 0;
  localparam int unsigned IE_TX    = 1;
  localparam int unsigned IE_EMPTY = 2;
endpackage

// File: rtl/uart_host_txbuf.sv
module uart_host_txbuf #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         clr_done,
  input  logic         shifter_busy,
  output logic         empty,
  output logic         done,
  output logic         start,
  output logic [W-1:0] start_data
);
  logic [W-1:0] hold_q, out_q;
  logic         empty_q, start_q, busy_q, done_q;
  logic         handoff;

  // move the held byte only when the shifter is idle and no start is in flight
  assign handoff = !empty_q && !shifter_busy && !start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      out_q   <= '0;
      empty_q <= 1'b1;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= handoff;
      busy_q  <= shifter_busy;
      if (handoff) out_q <= hold_q;
      if (load) begin
        hold_q  <= load_data;
        empty_q <= 1'b0;
      end else if (handoff) begin
        empty_q <= 1'b1;
      end
      if (busy_q && !shifter_busy) done_q <= 1'b1;
      else if (clr_done)           done_q <= 1'b0;
    end
  end

  assign empty      = empty_q;
  assign done       = done_q;
  assign start      = start_q;
  assign start_data = out_q;
endmodule

// File: rtl/uart_host_rxbuf.sv
module uart_host_rxbuf #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_stop,
  input  logic         take,
  input  logic         clr_done,
  output logic [W-1:0] data,
  output logic         done,
  output logic         fe,
  output logic         ovr,
  output logic         pending
);
  logic [W-1:0] data_q;
  logic         done_q, fe_q, ovr_q, pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      done_q <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (in_valid) begin
      data_q <= in_data;
      fe_q   <= !in_stop;
      done_q <= 1'b1;
      pend_q <= 1'b1;
      // a read in this same cycle consumed the old byte: no loss
      ovr_q  <= take ? 1'b0 : (ovr_q | pend_q);
    end else begin
      if (take) begin
        pend_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (clr_done) done_q <= 1'b0;
    end
  end

  assign data    = data_q;
  assign done    = done_q;
  assign fe      = fe_q;
  assign ovr     = ovr_q;
  assign pending = pend_q;
endmodule

// File: rtl/uart_host_irq.sv
module uart_host_irq #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  output logic [N-1:0] irq
);
  for (genvar g = 0; g < N; g++) begin : g_gate
    assign irq[g] = flag[g] & en[g];
  end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_busy,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_stop,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_empty
);
  logic              wr_data, wr_stat, wr_ien, rd_data;
  logic              tx_empty, tx_done, rx_done, rx_fe, rx_ovr, rx_pending;
  logic [DATA_W-1:0] rx_byte;
  logic [IRQ_N-1:0]  ien_q, flags, irqs;
  logic [STAT_W-1:0] stat;

  assign wr_data = bus_wr && (bus_addr == SEL_DATA);
  assign wr_stat = bus_wr && (bus_addr == SEL_STAT);
  assign wr_ien  = bus_wr && (bus_addr == SEL_IEN);
  assign rd_data = bus_rd && (bus_addr == SEL_DATA);

  uart_host_txbuf #(.W(DATA_W)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .load         (wr_data),
    .load_data    (bus_wdata),
    .clr_done     (wr_stat && bus_wdata[ST_TXC]),
    .shifter_busy (tx_busy),
    .empty        (tx_empty),
    .done         (tx_done),
    .start        (tx_start),
    .start_data   (tx_data)
  );

  uart_host_rxbuf #(.W(DATA_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .in_stop  (rx_stop),
    .take     (rd_data),
    .clr_done (wr_stat && bus_wdata[ST_RXC]),
    .data     (rx_byte),
    .done     (rx_done),
    .fe       (rx_fe),
    .ovr      (rx_ovr),
    .pending  (rx_pending)
  );

  always_ff @(posedge clk) begin
    if (rst)         ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[IRQ_N-1:0];
  end

  always_comb begin
    stat           = '0;
    stat[ST_RXC]   = rx_done;
    stat[ST_TXC]   = tx_done;
    stat[ST_EMPTY] = tx_empty;
    stat[ST_FE]    = rx_fe;
    stat[ST_OVR]   = rx_ovr;
  end

  always_comb begin
    flags           = '0;
    flags[IE_RX]    = rx_done;
    flags[IE_TX]    = tx_done;
    flags[IE_EMPTY] = tx_empty;
  end

  uart_host_irq #(.N(IRQ_N)) u_irq (
    .flag (flags),
    .en   (ien_q),
    .irq  (irqs)
  );

  assign irq_rx    = irqs[IE_RX];
  assign irq_tx    = irqs[IE_TX];
  assign irq_empty = irqs[IE_EMPTY];

  always_comb begin
    case (bus_addr)
      SEL_DATA: bus_rdata = rx_byte;
      SEL_STAT: bus_rdata = DATA_W'(stat);
      SEL_IEN:  bus_rdata = DATA_W'(ien_q);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_data,
  input logic       rd_data,
  input logic       tx_start,
  input logic       tx_busy,
  input logic       tx_empty,
  input logic       rx_valid,
  input logic       rx_stop,
  input logic       rx_pending,
  input logic       rx_done,
  input logic       rx_fe,
  input logic       rx_ovr,
  input logic       irq_empty
);
  a_r1_empty_after_reset: assert property (@(posedge clk)
    $past(rst) |-> tx_empty);

  a_r3_write_drops_empty_irq: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !irq_empty);

  a_r4_empty_at_handoff: assert property (@(posedge clk) disable iff (rst)
    (tx_start && !$past(wr_data)) |-> tx_empty);

  a_r5_no_start_while_busy: assert property (@(posedge clk) disable iff (rst)
    tx_busy |-> !tx_start);

  a_r7_rxc_on_char: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> rx_done);

  a_r8_fe_from_stop: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (rx_fe == !$past(rx_stop)));

  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_pending && !rd_data) |=> rx_ovr);
endmodule

bind uart_host_regs uart_host_regs_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .tx_start   (tx_start),
  .tx_busy    (tx_busy),
  .tx_empty   (tx_empty),
  .rx_valid   (rx_valid),
  .rx_stop    (rx_stop),
  .rx_pending (rx_pending),
  .rx_done    (rx_done),
  .rx_fe      (rx_fe),
  .rx_ovr     (rx_ovr),
  .irq_empty  (irq_empty)
);

// File: tb/uart_host_regs_test.sv
`timescale 1ns/100ps
module uart_host_regs_test;
  localparam int TX_LEN = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tx_start;
  logic [7:0] tx_data;
  logic       tx_busy;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_stop = 1'b1;
  logic       irq_rx, irq_tx, irq_empty;

  int nchk = 0, nerr = 0, nstart = 0, busy_cnt;
  logic [7:0] exp_q[$];
  logic [7:0] v;

  always #2.5 clk = ~clk;

  uart_host_regs uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_start(tx_start),
    .tx_data(tx_data), .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_stop(rx_stop), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_empty(irq_empty)
  );

  // transmit shifter model: busy from the edge that sees tx_start, for TX_LEN cycles
  always @(posedge clk) begin
    if (rst) begin
      tx_busy <= 1'b0; busy_cnt <= 0;
    end else if (tx_start) begin
      tx_busy <= 1'b1; busy_cnt <= TX_LEN;
    end else if (busy_cnt > 1) begin
      busy_cnt <= busy_cnt - 1;
    end else begin
      busy_cnt <= 0; tx_busy <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each handover is compared with the oldest expected byte (R4)
  always @(negedge clk) begin
    if (!rst && tx_start) begin
      nstart++;
      if (exp_q.size() == 0) begin
        chk(0, "R4 unexpected tx_start", tx_data, 0);
      end else begin
        v = exp_q.pop_front();
        chk(tx_data == v, "R4 tx_data", tx_data, v);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    wr(2'd0, b);
  endtask

  task automatic rx_char(input logic [7:0] b, input logic stop);
    rx_data = b; rx_stop = stop; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    logic [7:0] s, s2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    peek(2'd1, s);  chk(s == 8'h20, "R1 status after reset", s, 8'h20);
    chk(s[2:0] == 3'b000, "R2 unused status bits", s[2:0], 0);
    peek(2'd2, s);  chk(s == 8'h00, "R1 enable after reset", s, 0);
    chk({irq_rx, irq_tx, irq_empty} == 3'b000, "R1 irqs after reset", {irq_rx, irq_tx, irq_empty}, 0);
    chk(tx_start == 1'b0, "R1 tx_start after reset", tx_start, 0);

    wr(2'd2, 8'h07);
    chk(irq_empty == 1'b1, "R11 empty irq enabled", irq_empty, 1);

    // idle handover
    send_byte(8'hA5);
    peek(2'd1, s);
    chk(s[5] == 1'b0, "R3 empty cleared by write", s[5], 0);
    chk(irq_empty == 1'b0, "R11 empty irq dropped by refill", irq_empty, 0);
    chk(tx_start == 1'b0, "R4 no start yet", tx_start, 0);
    @(negedge clk);
    chk(tx_start == 1'b1, "R4 start one edge after write", tx_start, 1);
    chk(irq_empty == 1'b1, "R4 empty sets at handover", irq_empty, 1);
    @(negedge clk);
    chk(tx_start == 1'b0, "R4 start lasts one cycle", tx_start, 0);

    // write while shifter busy
    send_byte(8'h3C);
    peek(2'd1, s);
    chk(s == 8'h00, "R5 byte held while busy", s, 8'h00);
    repeat (5) @(negedge clk);
    chk(nstart == 1, "R5 no handover while busy", nstart, 1);
    while (tx_busy) @(negedge clk);
    @(negedge clk);
    chk(tx_start == 1'b1, "R5 handover after busy falls", tx_start, 1);
    chk(irq_tx == 1'b1, "R6 transmit-complete irq", irq_tx, 1);
    peek(2'd1, s);
    chk(s[6] == 1'b1, "R6 transmit-complete set", s[6], 1);

    wr(2'd1, 8'h00);
    peek(2'd1, s);
    chk(s[6] == 1'b1, "R6 write 0 keeps flag", s[6], 1);
    wr(2'd1, 8'h3F);
    peek(2'd1, s);
    chk(s == 8'h60, "R2 writes to bits 5..0 ignored", s, 8'h60);
    wr(2'd1, 8'h40);
    peek(2'd1, s);
    chk(s == 8'h20, "R6 write 1 clears", s, 8'h20);
    chk(irq_tx == 1'b0, "R11 tx irq follows flag", irq_tx, 0);

    // receive path
    rx_char(8'h5A, 1'b1);
    peek(2'd1, s);
    chk((s & 8'hB8) == 8'hA0, "R7 receive-complete set, R8 fe clear", s & 8'hB8, 8'hA0);
    chk(irq_rx == 1'b1, "R11 rx irq", irq_rx, 1);
    peek(2'd0, s);
    chk(s == 8'h5A, "R12 received byte", s, 8'h5A);
    rd(2'd1, s);
    rd(2'd1, s2);
    chk((s & 8'hB8) == (s2 & 8'hB8), "R10 status read no side effect", s2, s);
    chk(s2[7] == 1'b1, "R10 rxc survives status read", s2[7], 1);
    rd(2'd0, s);
    chk(s == 8'h5A, "R12 data read", s, 8'h5A);

    rx_char(8'h11, 1'b0);
    peek(2'd1, s);
    chk((s & 8'h18) == 8'h10, "R8 framing error on low stop", s & 8'h18, 8'h10);
    rx_char(8'h22, 1'b1);
    peek(2'd1, s);
    chk((s & 8'h18) == 8'h08, "R9 overrun set, R8 fe follows byte", s & 8'h18, 8'h08);
    rd(2'd0, s);
    chk(s == 8'h22, "R12 newest byte kept", s, 8'h22);
    peek(2'd1, s);
    chk(s[3] == 1'b0, "R9 overrun cleared by data read", s[3], 0);

    wr(2'd1, 8'h80);
    peek(2'd1, s);
    chk(s[7] == 1'b0, "R7 write 1 clears", s[7], 0);
    chk(irq_rx == 1'b0, "R11 rx irq cleared", irq_rx, 0);

    while (tx_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(irq_empty == 1'b1, "R11 empty irq persists", irq_empty, 1);
    wr(2'd2, 8'h03);
    peek(2'd1, s);
    chk(irq_empty == 1'b0 && s[5] == 1'b1, "R11 empty irq masked, flag kept", {irq_empty, s[5]}, 2'b01);
    chk(irq_tx == 1'b1, "R6 second character complete", irq_tx, 1);

    chk(exp_q.size() == 0 && nstart == 2, "R4 all bytes handed over", nstart, 2);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule